// File: doc/BRIEF.md
# Regulator Power-Good Window Monitor

This block produces the power-good indication of a multiphase core-voltage regulator. On each evaluation strobe it compares a sampled output-voltage code with the current DAC target code. Both codes are unsigned and are scaled in millivolts. The output counts as good when it sits inside an asymmetric window around the target. The window reaches 300 mV below the target and 200 mV above it. The lower limit is dropped entirely while the target is under 300 mV. Power-good is held low until the startup sequence reports that its post-clock-enable delay has finished.

System transitions would otherwise cause false alarms. A VID change, a deeper-sleep entry or exit, or the start of an overcurrent event each freezes power-good at its present value for a fixed mask period. A further trigger during the mask restarts the full period.

The block also runs two protection functions. A current limit held for the latch-off delay shuts the regulator off and forces power-good low until the enable input is cycled. An absolute overvoltage of 1.55 V or more raises a crowbar flag, whatever the DAC setting. With enable low, every output and timer is cleared.

Top module: `pgw_monitor`

## Requirements
- R1: On an unmasked valid sample, with startup done, power-good is high at the next clock edge when dac_mv-300 <= vout_mv <= dac_mv+200. Both limits are inclusive.
- R2: While dac_mv < 300, only the upper limit applies, so any vout_mv up to dac_mv+200, including 0, is good.
- R3: Outside a mask, a valid sample above the upper limit or below an applicable lower limit drives power-good low at the next clock edge.
- R4: While startup_done is low, power-good stays low whatever the samples are.
- R5: A mask trigger is a vid_chg pulse, a slp_chg pulse or a 0-to-1 edge of ilim. The clock edge that samples a trigger and the following MASK_CYC (default 100) edges hold power-good at its value. The next edge after those evaluates normally again.
- R6: A trigger that arrives while a mask is running restarts the full MASK_CYC period from that trigger.
- R7: crowbar is updated on each valid sample and is high exactly when vout_mv >= 1550. It does not depend on dac_mv. Samples are taken only while enabled.
- R8: If ilim is high on LATCH_CYC (default 8) consecutive clock edges, latch_off rises on the last of those edges. A low cycle on ilim restarts the count.
- R9: While latch_off is high, power-good is low from the next edge onward. latch_off stays set until en is low on a clock edge.
- R10: When en is low, power-good, latch_off and crowbar are low at the next edge, and any running mask is cleared. After re-enable, the first in-window sample raises power-good at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Regulator enable; low means shutdown and clears the latch-off |
| sample_vld | input | 1 | Evaluation strobe for vout_mv |
| vout_mv | input | 12 | Sampled output voltage in mV, relative to the sense return |
| dac_mv | input | 12 | Present DAC target in mV |
| startup_done | input | 1 | Startup sequence finished, including the delay after clock enable |
| vid_chg | input | 1 | One-cycle pulse on a VID code change |
| slp_chg | input | 1 | One-cycle pulse on deeper-sleep entry or exit |
| ilim | input | 1 | Current-limit comparator level |
| pwr_good | output | 1 | Power-good indication |
| latch_off | output | 1 | Sustained-overcurrent shutdown latch |
| crowbar | output | 1 | Absolute overvoltage flag |

## Verification
The assertions check on every cycle the rules that relate neighbouring edges:
- power-good falls after shutdown or latch-off;
- power-good is frozen while the mask is active;
- power-good drops after an unmasked out-of-window sample;
- power-good rises only with startup done;
- the latch stays set while enabled;
- the mask counter reloads on each trigger.

The bench scenarios are needed for everything that depends on counting or on exact codes. These are the inclusive window limits, the dropped lower limit at low DAC codes, the exact length of the mask and of its restart, the eight-cycle latch-off threshold and its reset by a gap in ilim, and the clearing of a pending mask by a shutdown.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  // Decision taken for the power-good register on one clock edge
  typedef enum logic [1:0] {
    PG_FORCE_LOW = 2'd0,
    PG_HOLD      = 2'd1,
    PG_EVAL      = 2'd2
  } pg_act_e;

  // Default code width in millivolt units
  localparam int unsigned CODE_W_DEF = 12;

endpackage

// File: rtl/pgw_window.sv
module pgw_window #(
  parameter int unsigned CODE_W     = 12,
  parameter int unsigned UV_OFS_MV  = 300,
  parameter int unsigned OV_OFS_MV  = 200,
  parameter int unsigned CROWBAR_MV = 1550
) (
  input  logic [CODE_W-1:0] vout_mv,
  input  logic [CODE_W-1:0] dac_mv,
  output logic              in_win,
  output logic              over_cb
);
  localparam int unsigned EW = CODE_W + 1;
  localparam logic [EW-1:0] UV_E = EW'(UV_OFS_MV);
  localparam logic [EW-1:0] OV_E = EW'(OV_OFS_MV);
  localparam logic [EW-1:0] CB_E = EW'(CROWBAR_MV);

  logic [EW-1:0] vout_e;
  logic [EW-1:0] dac_e;
  logic [EW-1:0] upper_lim;
  logic [EW-1:0] lower_lim;
  logic          low_dac;
  logic          above_ok;
  logic          below_ok;

  always_comb begin
    vout_e    = {1'b0, vout_mv};
    dac_e     = {1'b0, dac_mv};
    upper_lim = dac_e + OV_E;
    low_dac   = (dac_e < UV_E);
    // lower limit only computed where it cannot wrap
    lower_lim = low_dac ? '0 : (dac_e - UV_E);
    above_ok  = (vout_e <= upper_lim);
    below_ok  = low_dac | (vout_e >= lower_lim);
    in_win    = above_ok & below_ok;
    over_cb   = (vout_e >= CB_E);
  end

endmodule

// File: rtl/pgw_mask_timer.sv
module pgw_mask_timer #(
  parameter int unsigned MASK_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic trig,
  output logic masked
);
  localparam int unsigned CNT_W = $clog2(MASK_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(MASK_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | trig | (cnt_q != '0);
    cnt_d  = cnt_q;
    if (clr)                cnt_d = '0;
    else if (trig)          cnt_d = LOAD_V;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_en)  cnt_q <= cnt_d;
  end

  assign masked = ~clr & (trig | (cnt_q != '0));

  AST_MASK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !clr) |=> (cnt_q == LOAD_V)); // R6

  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/pgw_latchoff.sv
module pgw_latchoff #(
  parameter int unsigned LATCH_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ilim,
  output logic latch_off,
  output logic oc_evt
);
  localparam int unsigned CNT_W = $clog2(LATCH_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LATCH_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lat_q, lat_d;
  logic             ilim_q, ilim_d;
  logic             run;

  always_comb begin
    run    = en & ~lat_q;
    cnt_d  = cnt_q;
    lat_d  = lat_q;
    ilim_d = run & ilim;
    if (!en) begin
      cnt_d = '0;
      lat_d = 1'b0;
    end else if (!lat_q) begin
      if (!ilim) begin
        cnt_d = '0;
      end else if (cnt_q == LAST_V) begin
        cnt_d = '0;
        lat_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lat_q  <= 1'b0;
      ilim_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lat_q  <= lat_d;
      ilim_q <= ilim_d;
    end
  end

  assign latch_off = lat_q;
  assign oc_evt    = run & ilim & ~ilim_q;

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && en) |=> lat_q); // R9

  AST_LATCH_NEEDS_ILIM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_q) |-> $past(ilim)); // R8

endmodule

// File: rtl/pgw_monitor.sv
module pgw_monitor
  import pgw_pkg::*;
#(
  parameter int unsigned CODE_W     = CODE_W_DEF,
  parameter int unsigned UV_OFS_MV  = 300,
  parameter int unsigned OV_OFS_MV  = 200,
  parameter int unsigned CROWBAR_MV = 1550,
  parameter int unsigned MASK_CYC   = 100,
  parameter int unsigned LATCH_CYC  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sample_vld,
  input  logic [CODE_W-1:0] vout_mv,
  input  logic [CODE_W-1:0] dac_mv,
  input  logic              startup_done,
  input  logic              vid_chg,
  input  logic              slp_chg,
  input  logic              ilim,
  output logic              pwr_good,
  output logic              latch_off,
  output logic              crowbar
);
  logic    in_win, over_cb;
  logic    oc_evt, masked, active, trig;
  logic    pg_q, pg_d;
  logic    cb_q, cb_d;
  pg_act_e pg_act;

  pgw_window #(
    .CODE_W(CODE_W), .UV_OFS_MV(UV_OFS_MV),
    .OV_OFS_MV(OV_OFS_MV), .CROWBAR_MV(CROWBAR_MV)
  ) u_win (
    .vout_mv(vout_mv), .dac_mv(dac_mv),
    .in_win(in_win), .over_cb(over_cb)
  );

  pgw_latchoff #(.LATCH_CYC(LATCH_CYC)) u_lat (
    .clk(clk), .rst_n(rst_n), .en(en), .ilim(ilim),
    .latch_off(latch_off), .oc_evt(oc_evt)
  );

  assign active = en & ~latch_off;
  assign trig   = active & (vid_chg | slp_chg | oc_evt);

  pgw_mask_timer #(.MASK_CYC(MASK_CYC)) u_mask (
    .clk(clk), .rst_n(rst_n), .clr(~active), .trig(trig), .masked(masked)
  );

  always_comb begin
    if (!active || !startup_done)  pg_act = PG_FORCE_LOW;
    else if (masked || !sample_vld) pg_act = PG_HOLD;
    else                            pg_act = PG_EVAL;
    unique case (pg_act)
      PG_FORCE_LOW: pg_d = 1'b0;
      PG_EVAL:      pg_d = in_win;
      default:      pg_d = pg_q;
    endcase
    cb_d = cb_q;
    if (!en)             cb_d = 1'b0;
    else if (sample_vld) cb_d = over_cb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= 1'b0;
      cb_q <= 1'b0;
    end else begin
      pg_q <= pg_d;
      cb_q <= cb_d;
    end
  end

  assign pwr_good = pg_q;
  assign crowbar  = cb_q;

  AST_PG_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || latch_off) |=> !pwr_good); // R10

  AST_PG_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (masked && startup_done) |=> $stable(pwr_good)); // R5

  AST_PG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !in_win && !masked) |=> !pwr_good); // R3

  AST_PG_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good) |-> $past(startup_done)); // R4

  AST_CB_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sample_vld && vout_mv >= CODE_W'(CROWBAR_MV)) |=> crowbar); // R7

endmodule

// File: tb/pgw_monitor_test.sv
`timescale 1ns/1ps
module pgw_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n, en, sample_vld, startup_done, vid_chg, slp_chg, ilim;
  logic [11:0] vout_mv, dac_mv;
  logic        pwr_good, latch_off, crowbar;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pgw_monitor uut (
    .clk(clk), .rst_n(rst_n), .en(en), .sample_vld(sample_vld),
    .vout_mv(vout_mv), .dac_mv(dac_mv), .startup_done(startup_done),
    .vid_chg(vid_chg), .slp_chg(slp_chg), .ilim(ilim),
    .pwr_good(pwr_good), .latch_off(latch_off), .crowbar(crowbar)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R10 reset pwr_good", pwr_good, 1'b0);
    chk("R10 reset latch_off", latch_off, 1'b0);
    chk("R10 reset crowbar", crowbar, 1'b0);
  endtask

  task automatic t_window; // R1 R3
    dac_mv = 12'd1000;
    vout_mv = 12'd700;  step(1); chk("R1 lower edge good", pwr_good, 1'b1);
    vout_mv = 12'd1200; step(1); chk("R1 upper edge good", pwr_good, 1'b1);
    vout_mv = 12'd1201; step(1); chk("R3 above upper", pwr_good, 1'b0);
    vout_mv = 12'd1000; step(1); chk("R1 centre good", pwr_good, 1'b1);
    vout_mv = 12'd699;  step(1); chk("R3 below lower", pwr_good, 1'b0);
  endtask

  task automatic t_lowdac; // R2
    dac_mv = 12'd250;
    vout_mv = 12'd0;   step(1); chk("R2 zero good at low dac", pwr_good, 1'b1);
    vout_mv = 12'd450; step(1); chk("R2 upper edge low dac", pwr_good, 1'b1);
    vout_mv = 12'd451; step(1); chk("R2 above upper low dac", pwr_good, 1'b0);
    dac_mv = 12'd310; vout_mv = 12'd5; step(1);
    chk("R2 lower applies at 310", pwr_good, 1'b0);
    dac_mv = 12'd1000; vout_mv = 12'd1000; step(1);
  endtask

  task automatic t_startup; // R4
    startup_done = 1'b0; step(3);
    chk("R4 gated before startup", pwr_good, 1'b0);
    startup_done = 1'b1; step(1);
    chk("R4 rises after startup", pwr_good, 1'b1);
  endtask

  task automatic t_mask; // R5
    vout_mv = 12'd1300; vid_chg = 1'b1; step(1); vid_chg = 1'b0;
    chk("R5 vid trigger edge held", pwr_good, 1'b1);
    step(100); chk("R5 held through last masked edge", pwr_good, 1'b1);
    step(1);   chk("R5 evaluates after mask", pwr_good, 1'b0);
    vout_mv = 12'd1000; step(1);
    vout_mv = 12'd1300; slp_chg = 1'b1; step(1); slp_chg = 1'b0;
    step(50);  chk("R5 sleep trigger holds", pwr_good, 1'b1);
    step(51);  chk("R5 sleep mask ends", pwr_good, 1'b0);
    vout_mv = 12'd1000; step(1);
  endtask

  task automatic t_retrigger; // R6
    vout_mv = 12'd1300; vid_chg = 1'b1; step(1); vid_chg = 1'b0;
    step(60);
    slp_chg = 1'b1; step(1); slp_chg = 1'b0;
    step(100); chk("R6 restarted mask still holds", pwr_good, 1'b1);
    step(1);   chk("R6 restarted mask ends", pwr_good, 1'b0);
    vout_mv = 12'd1000; step(1);
  endtask

  task automatic t_crowbar; // R7
    dac_mv = 12'd500; vout_mv = 12'd1549; step(1);
    chk("R7 below crowbar", crowbar, 1'b0);
    vout_mv = 12'd1550; step(1);
    chk("R7 at crowbar", crowbar, 1'b1);
    dac_mv = 12'd1500; vout_mv = 12'd1600; step(1);
    chk("R7 crowbar independent of dac", crowbar, 1'b1);
    chk("R1 in window at high dac", pwr_good, 1'b1);
    dac_mv = 12'd1000; vout_mv = 12'd1000; step(1);
    chk("R7 crowbar clears", crowbar, 1'b0);
  endtask

  task automatic t_latch; // R8 R9 R10
    ilim = 1'b1; step(5); ilim = 1'b0; step(1); ilim = 1'b1; step(5);
    chk("R8 gap restarts count", latch_off, 1'b0);
    ilim = 1'b0; step(105);
    vout_mv = 12'd1300; ilim = 1'b1; step(1);
    chk("R5 overcurrent edge masks", pwr_good, 1'b1);
    step(6); chk("R8 no latch at 7", latch_off, 1'b0);
    step(1); chk("R8 latch at 8", latch_off, 1'b1);
    step(1); chk("R9 pg low under latch", pwr_good, 1'b0);
    ilim = 1'b0; vout_mv = 12'd1000; step(5);
    chk("R9 latch sticky", latch_off, 1'b1);
    chk("R9 pg stays low", pwr_good, 1'b0);
    en = 1'b0; step(1);
    chk("R10 disable clears latch", latch_off, 1'b0);
    en = 1'b1; step(1);
    chk("R10 re-enable pg", pwr_good, 1'b1);
  endtask

  task automatic t_shutdown; // R10
    vid_chg = 1'b1; step(1); vid_chg = 1'b0; step(3);
    en = 1'b0; step(1);
    chk("R10 shutdown pg low", pwr_good, 1'b0);
    en = 1'b1; step(1);
    chk("R10 mask cleared by shutdown", pwr_good, 1'b1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; sample_vld = 1'b1; startup_done = 1'b1;
    vid_chg = 1'b0; slp_chg = 1'b0; ilim = 1'b0;
    vout_mv = 12'd1000; dac_mv = 12'd1000;
    step(3);
    t_reset();
    rst_n = 1'b1; en = 1'b1; step(1);
    t_window();
    t_lowdac();
    t_startup();
    t_mask();
    t_retrigger();
    t_crowbar();
    t_latch();
    t_shutdown();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule